// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block sits inside a storage bus-master DMA engine. It moves the contents of a local sector buffer to or from host memory. It follows a table of 8-byte region descriptors held in host memory. Each descriptor names one physical region: its start address, its length and whether it is the final entry.

After a start pulse the walker reads descriptors one at a time over a simple read port. For each descriptor it issues data bursts over a second port. Each burst carries a host address, a byte length, an offset into the local buffer and a direction bit. The walker finishes when the buffer has been fully transferred. It also finishes when the table runs out first, and in that case it raises a flag saying so. A fail-safe bounds the walk. No descriptor is fetched once the table pointer is a page or more past the base, even if no entry ever carries the final mark.

Top module: `sg_walker`

## Requirements
- R1: Descriptor format. Word 0 is `desc_data[31:0]`, the region address. In word 1 (`desc_data[63:32]`), bits 15:0 give the byte count with bit 0 forced to zero, and bit 31 is the final-entry mark. Bits 30:16 of word 1 are ignored.
- R2: A masked byte count of zero means a region of 65536 bytes.
- R3: The first fetch of a run reads at `table_base`. Each later fetch reads 8 bytes past the previous one. A descriptor is fetched only when the current region has no bytes left.
- R4: Each burst length is the smaller of the bytes left in the buffer and the bytes left in the current region, and is never zero. After each burst, the region address and the buffer offset advance by that length, and the region's remaining count shrinks by it.
- R5: `burst_write` equals the value `to_host` had when the run started. 1 means buffer to host memory; 0 means host memory to buffer.
- R6: If a region marked final is used up while buffer bytes remain, no further fetch occurs. The run ends with `done` and `ended_early` both at 1.
- R7: Once the table pointer is `PAGE_BYTES` or more past the base and the current region is used up, no further fetch occurs. The run ends with `ended_early` at 1.
- R8: When the buffer is fully transferred, `done` pulses for exactly one cycle with `ended_early` at 0. A `buf_bytes` of 0 ends the run without any fetch.
- R9: A start clears the region state left over from the previous run. Leftover bytes of an old region are never used, and the walk restarts at the base.
- R10: A start pulse that arrives while a run is in progress has no effect on that run.
- R11: While in reset and after it, `desc_req`, `burst_req` and `done` are 0.
- R12: A request stays asserted, with a stable address, until it is acknowledged. No two of `desc_req`, `burst_req` and `done` are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| to_host | input | 1 | Direction for the run: 1 = buffer to host memory |
| table_base | input | 32 | Host address of the first descriptor |
| buf_bytes | input | BUF_W | Number of buffered bytes to move |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | 32 | Address of the descriptor being read |
| desc_ack | input | 1 | Descriptor read completes; data valid |
| desc_data | input | 64 | Descriptor contents, little-endian words |
| burst_req | output | 1 | Data burst request |
| burst_write | output | 1 | 1 = write to host memory, 0 = read from it |
| burst_addr | output | 32 | Host address of the burst |
| burst_len | output | CNT_W | Burst byte count |
| burst_buf_idx | output | BUF_W | Offset of the burst in the local buffer |
| burst_ack | input | 1 | Burst completes |
| done | output | 1 | One-cycle end-of-run pulse |
| ended_early | output | 1 | Table ended before the buffer drained; valid with done |

## Verification
A wrong region length or address in the walker shows up at the very next burst. The burst's length, host address or buffer offset departs from a reference walk, which the bench computes from the table it placed in its model memory. A wrong table pointer or a missed clear at start shows up at the next descriptor read as an unexpected address, or as a fetch that is missing or extra. Wrong stop logic shows up at the end of the run as a mismatch in `ended_early` or in the number of fetches. Every run is compared burst by burst and fetch by fetch, so a fault appears within one handshake of where it arises.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int SGW_ADDR_W  = 32;
  localparam int SGW_SPAN_W  = 17;  // one region holds up to 65536 bytes

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_FETCH  = 2'd2,
    ST_MOVE   = 2'd3
  } sgw_state_e;

  typedef struct packed {
    logic [SGW_ADDR_W-1:0] addr;
    logic [SGW_SPAN_W-1:0] span;
    logic                  final_mark;
  } sgw_region_t;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
(
  input  logic [63:0]  raw,
  output sgw_region_t  region
);
  logic [15:0] even_cnt;

  always_comb begin
    even_cnt          = {raw[47:33], 1'b0};
    region.addr       = raw[31:0];
    region.final_mark = raw[63];
    if (even_cnt == 16'd0) begin
      region.span = 17'h10000;
    end else begin
      region.span = {1'b0, even_cnt};
    end
  end
endmodule

// File: rtl/sgw_step.sv
module sgw_step
  import sgw_pkg::*;
#(
  parameter int BUF_W      = 16,
  parameter int CNT_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [BUF_W-1:0]      rem_bytes,
  input  logic [CNT_W-1:0]      span_left,
  input  logic                  span_final,
  input  logic [SGW_ADDR_W-1:0] tbl_ptr,
  input  logic [SGW_ADDR_W-1:0] tbl_base,
  output logic                  buf_empty,
  output logic                  span_empty,
  output logic                  table_stop,
  output logic [CNT_W-1:0]      step_len
);
  localparam logic [SGW_ADDR_W-1:0] PAGE_LIM = SGW_ADDR_W'(PAGE_BYTES);

  logic [CNT_W-1:0]      rem_wide;
  logic [SGW_ADDR_W-1:0] walked;

  always_comb begin
    rem_wide   = CNT_W'(rem_bytes);
    walked     = tbl_ptr - tbl_base;
    buf_empty  = (rem_bytes == '0);
    span_empty = (span_left == '0);
    table_stop = span_final || (walked >= PAGE_LIM);
    step_len   = (rem_wide < span_left) ? rem_wide : span_left;
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int BUF_W      = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int CNT_W     = (BUF_W > SGW_SPAN_W) ? BUF_W : SGW_SPAN_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  to_host,
  input  logic [SGW_ADDR_W-1:0] table_base,
  input  logic [BUF_W-1:0]      buf_bytes,
  output logic                  desc_req,
  output logic [SGW_ADDR_W-1:0] desc_addr,
  input  logic                  desc_ack,
  input  logic [63:0]           desc_data,
  output logic                  burst_req,
  output logic                  burst_write,
  output logic [SGW_ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]      burst_len,
  output logic [BUF_W-1:0]      burst_buf_idx,
  input  logic                  burst_ack,
  output logic                  done,
  output logic                  ended_early
);
  sgw_state_e            state_q;
  logic [SGW_ADDR_W-1:0] base_q, ptr_q, raddr_q;
  logic [CNT_W-1:0]      rlen_q, blen_q;
  logic                  rfinal_q, dir_q, done_q, early_q;
  logic [BUF_W-1:0]      rem_q, idx_q;

  sgw_region_t           fetched;
  logic                  buf_empty, span_empty, table_stop;
  logic [CNT_W-1:0]      step_len;

  sgw_desc_decode u_decode (
    .raw    (desc_data),
    .region (fetched)
  );

  sgw_step #(
    .BUF_W      (BUF_W),
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_step (
    .rem_bytes  (rem_q),
    .span_left  (rlen_q),
    .span_final (rfinal_q),
    .tbl_ptr    (ptr_q),
    .tbl_base   (base_q),
    .buf_empty  (buf_empty),
    .span_empty (span_empty),
    .table_stop (table_stop),
    .step_len   (step_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      ptr_q    <= '0;
      raddr_q  <= '0;
      rlen_q   <= '0;
      rfinal_q <= 1'b0;
      blen_q   <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      early_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          done_q <= 1'b0;
          if (start) begin
            base_q   <= {table_base[SGW_ADDR_W-1:3], 3'b000} | (table_base & 32'h7);
            ptr_q    <= table_base;
            raddr_q  <= '0;
            rlen_q   <= '0;
            rfinal_q <= 1'b0;
            rem_q    <= buf_bytes;
            idx_q    <= '0;
            dir_q    <= to_host;
            early_q  <= 1'b0;
            state_q  <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (buf_empty) begin
            done_q  <= 1'b1;
            early_q <= 1'b0;
            state_q <= ST_IDLE;
          end else if (span_empty) begin
            if (table_stop) begin
              done_q  <= 1'b1;
              early_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_FETCH;
            end
          end else begin
            blen_q  <= step_len;
            state_q <= ST_MOVE;
          end
        end
        ST_FETCH: begin
          if (desc_ack) begin
            raddr_q  <= fetched.addr;
            rlen_q   <= CNT_W'(fetched.span);
            rfinal_q <= fetched.final_mark;
            ptr_q    <= ptr_q + SGW_ADDR_W'(8);
            state_q  <= ST_DECIDE;
          end
        end
        ST_MOVE: begin
          if (burst_ack) begin
            raddr_q <= raddr_q + SGW_ADDR_W'(blen_q);
            rlen_q  <= rlen_q - blen_q;
            idx_q   <= idx_q + BUF_W'(blen_q);
            rem_q   <= rem_q - BUF_W'(blen_q);
            state_q <= ST_DECIDE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign desc_req      = (state_q == ST_FETCH);
  assign desc_addr     = ptr_q;
  assign burst_req     = (state_q == ST_MOVE);
  assign burst_write   = dir_q;
  assign burst_addr    = raddr_q;
  assign burst_len     = blen_q;
  assign burst_buf_idx = idx_q;
  assign done          = done_q;
  assign ended_early   = early_q;
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int BUF_W = 16,
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_req,
  input logic [31:0]      desc_addr,
  input logic             desc_ack,
  input logic             burst_req,
  input logic [31:0]      burst_addr,
  input logic [CNT_W-1:0] burst_len,
  input logic [BUF_W-1:0] burst_buf_idx,
  input logic             burst_ack,
  input logic             done
);
  // R12
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({desc_req, burst_req, done}));
  // R12
  desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    desc_req && !desc_ack |=> desc_req && $stable(desc_addr));
  // R12
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req && !burst_ack |=> burst_req && $stable(burst_addr) && $stable(burst_len));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    desc_req && desc_ack |=> desc_addr == $past(desc_addr) + 32'd8);
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req && burst_ack |=> burst_buf_idx == $past(burst_buf_idx) + BUF_W'($past(burst_len)));
  // R4
  nonzero_len_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> burst_len != '0);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sg_walker sg_walker_chk #(.BUF_W(BUF_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .desc_req      (desc_req),
  .desc_addr     (desc_addr),
  .desc_ack      (desc_ack),
  .burst_req     (burst_req),
  .burst_addr    (burst_addr),
  .burst_len     (burst_len),
  .burst_buf_idx (burst_buf_idx),
  .burst_ack     (burst_ack),
  .done          (done)
);

// File: tb/sg_walker_tb.sv
module sg_walker_tb;
  localparam int BUF_W = 16;
  localparam int CNT_W = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, to_host = 1'b0;
  logic [31:0] table_base = '0;
  logic [BUF_W-1:0] buf_bytes = '0;
  logic desc_req, burst_req, burst_write, done, ended_early;
  logic [31:0] desc_addr, burst_addr;
  logic desc_ack = 1'b0, burst_ack = 1'b0;
  logic [63:0] desc_data = '0;
  logic [CNT_W-1:0] burst_len;
  logic [BUF_W-1:0] burst_buf_idx;

  always #2 clk = ~clk;  // 250 MHz

  sg_walker #(.BUF_W(BUF_W), .PAGE_BYTES(4096)) u_dut (
    .clk(clk), .rst(rst), .start(start), .to_host(to_host),
    .table_base(table_base), .buf_bytes(buf_bytes),
    .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
    .desc_data(desc_data), .burst_req(burst_req), .burst_write(burst_write),
    .burst_addr(burst_addr), .burst_len(burst_len),
    .burst_buf_idx(burst_buf_idx), .burst_ack(burst_ack),
    .done(done), .ended_early(ended_early)
  );

  typedef struct {
    logic [31:0] addr;
    int          len;
    int          idx;
    bit          wr;
  } burst_t;

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] dmem [logic [31:0]];
  burst_t      exp_burst[$];
  logic [31:0] exp_desc[$];
  string       cur_tag = "R11";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkd(input logic [31:0] a, input logic [15:0] cnt,
                                      input bit fin, input logic [14:0] junk);
    return {fin, junk, cnt, a};
  endfunction

  // Monitor and memory responder
  always @(negedge clk) begin
    if (desc_ack) begin
      desc_ack = 1'b0;
    end else if (desc_req) begin
      if (exp_desc.size() == 0) begin
        check(0, cur_tag, "unexpected descriptor fetch", desc_addr, 0);
      end else begin
        logic [31:0] e;
        e = exp_desc.pop_front();
        check(desc_addr == e, cur_tag, "descriptor address", desc_addr, e);
      end
      desc_data = dmem.exists(desc_addr) ? dmem[desc_addr] : 64'd0;
      desc_ack  = 1'b1;
    end
    if (burst_ack) begin
      burst_ack = 1'b0;
    end else if (burst_req) begin
      if (exp_burst.size() == 0) begin
        check(0, cur_tag, "unexpected burst", burst_addr, 0);
      end else begin
        burst_t e;
        e = exp_burst.pop_front();
        check(burst_addr == e.addr, cur_tag, "burst address", burst_addr, e.addr);
        check(int'(burst_len) == e.len, cur_tag, "burst length", burst_len, e.len);
        check(int'(burst_buf_idx) == e.idx, cur_tag, "buffer offset", burst_buf_idx, e.idx);
        check(burst_write == e.wr, "R5", "direction", burst_write, e.wr);
      end
      burst_ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reference walk computed from the requirements
  task automatic model(input logic [31:0] base, input int nbytes, input bit wr,
                       output bit early);
    logic [31:0] ptr, caddr;
    int clen, rem, idx, l;
    bit fin;
    logic [63:0] d;
    burst_t it;
    ptr = base; caddr = '0; clen = 0; fin = 0; rem = nbytes; idx = 0; early = 0;
    while (rem > 0) begin
      if (clen == 0) begin
        if (fin || (ptr - base) >= 32'd4096) begin
          early = 1;
          break;
        end
        d = dmem.exists(ptr) ? dmem[ptr] : 64'd0;
        exp_desc.push_back(ptr);
        caddr = d[31:0];
        clen  = int'(d[47:32]) & 32'hFFFE;
        if (clen == 0) clen = 65536;
        fin = d[63];
        ptr = ptr + 32'd8;
      end else begin
        l = (rem < clen) ? rem : clen;
        it.addr = caddr; it.len = l; it.idx = idx; it.wr = wr;
        exp_burst.push_back(it);
        caddr = caddr + 32'(l);
        clen -= l; idx += l; rem -= l;
      end
    end
  endtask

  task automatic run_case(input string tag, input logic [31:0] base, input int nbytes,
                          input bit wr, input bit exp_early, input bit dup_start);
    bit early_m;
    int waited;
    cur_tag = tag;
    model(base, nbytes, wr, early_m);
    check(early_m == exp_early, tag, "reference early flag", early_m, exp_early);
    @(negedge clk);
    table_base = base; buf_bytes = BUF_W'(nbytes); to_host = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dup_start) begin
      repeat (3) @(negedge clk);
      table_base = 32'hDEAD_0000; buf_bytes = 16'd7; to_host = ~wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0; to_host = wr;
    end
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, tag, "done seen", done, 1);
    check(ended_early == exp_early, tag, "ended_early", ended_early, exp_early);
    check(exp_burst.size() == 0, tag, "bursts missing", exp_burst.size(), 0);
    check(exp_desc.size() == 0, tag, "fetches missing", exp_desc.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done is one cycle", done, 0);
    exp_burst.delete();
    exp_desc.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(desc_req == 1'b0, "R11", "desc_req in reset", desc_req, 0);
    check(burst_req == 1'b0, "R11", "burst_req in reset", burst_req, 0);
    check(done == 1'b0, "R11", "done in reset", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(desc_req == 1'b0 && burst_req == 1'b0, "R11", "idle after reset",
          {desc_req, burst_req}, 0);

    // R8: single region matches buffer, write direction
    dmem.delete();
    dmem[32'h1000] = mkd(32'h0002_0000, 16'd512, 1, 15'h0);
    run_case("R8", 32'h1000, 512, 1'b1, 1'b0, 1'b0);

    // R4: buffer smaller than region
    dmem.delete();
    dmem[32'h2000] = mkd(32'h0003_0000, 16'd1000, 0, 15'h0);
    run_case("R4", 32'h2000, 300, 1'b0, 1'b0, 1'b0);
    // R9: same table again; leftover region bytes must not be reused
    run_case("R9", 32'h2000, 300, 1'b1, 1'b0, 1'b0);

    // R1 and R3: odd count forced even, junk flag bits ignored, chained fetches
    dmem.delete();
    dmem[32'h3000] = mkd(32'h0004_0001, 16'd101, 0, 15'h7FFF);
    dmem[32'h3008] = mkd(32'h0005_0000, 16'd64, 1, 15'h1234);
    run_case("R1", 32'h3000, 164, 1'b0, 1'b0, 1'b0);
    run_case("R3", 32'h3000, 150, 1'b1, 1'b0, 1'b0);

    // R6: table ends before buffer drains
    dmem.delete();
    dmem[32'h4000] = mkd(32'h0006_0000, 16'd10, 1, 15'h0);
    run_case("R6", 32'h4000, 50, 1'b1, 1'b1, 1'b0);

    // R2: zero count means 65536
    dmem.delete();
    dmem[32'h5000] = mkd(32'h0007_0000, 16'd0, 1, 15'h2AAA);
    run_case("R2", 32'h5000, 3000, 1'b0, 1'b0, 1'b0);
    // R2: count of 1 masks to zero, so also 65536
    dmem.delete();
    dmem[32'h5100] = mkd(32'h0007_8000, 16'd1, 1, 15'h0);
    run_case("R2", 32'h5100, 40000, 1'b1, 1'b0, 1'b0);

    // R7: no final mark; page fail-safe ends the walk
    dmem.delete();
    for (int i = 0; i < 600; i++)
      dmem[32'h0010_0000 + 32'(i * 8)] = mkd(32'h0100_0000 + 32'(i * 16), 16'd2, 0, 15'h0);
    run_case("R7", 32'h0010_0000, 2000, 1'b0, 1'b1, 1'b0);

    // R8: empty buffer, no fetch at all
    dmem.delete();
    run_case("R8", 32'h6000, 0, 1'b1, 1'b0, 1'b0);

    // R10: second start during a run is ignored
    dmem.delete();
    dmem[32'h7000] = mkd(32'h0008_0000, 16'd40, 0, 15'h0);
    dmem[32'h7008] = mkd(32'h0009_0000, 16'd40, 0, 15'h0);
    dmem[32'h7010] = mkd(32'h000A_0000, 16'd40, 1, 15'h0);
    run_case("R10", 32'h7000, 100, 1'b1, 1'b0, 1'b1);

    repeat (4) @(negedge clk);
    check(desc_req == 1'b0 && burst_req == 1'b0, "R10", "idle after run",
          {desc_req, burst_req}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule